// File: doc/BRIEF.md
# Hardware Task Scheduler and Context Switcher

This block decides which hardware task should occupy a single reconfigurable region and then sequences the swap. It holds a two-bit status for every task. A task's identifier is also its priority, and a smaller number means a more urgent task. When asked for a decision, the block finds the task currently marked running. It then looks for the most urgent waiting task whose number is below that running task. If there is none, it reports a sentinel equal to the task count and does nothing.

When a switch is due, the outgoing task is handled in one of two ways. If it has already reported completion, it is retired with no further action. Otherwise it is asked to pause at a safe point, and its intermediate values are saved through a handshake. The incoming task is then started in one of two ways. A task that was paused earlier is resumed by restoring its saved values. Any other task is brought in fresh: the block requests a reconfiguration of the region, pulses a reset and then pulses a start. The configuration port and the memory that holds saved state are outside this block. Both are reached only through request/acknowledge pairs.

Top module: `hw_task_switch`

## Requirements
- R1: Each task has a 2-bit status with the encoding 00 stopped, 01 ready, 10 running, 11 preempted. After reset every task is stopped. A ready request for a stopped task makes it ready; a ready request for a task in any other status leaves that status unchanged.
- R2: A decision picks the lowest-numbered task whose status is ready or preempted and whose number is below the running task's number. When no task is running, every task is eligible.
- R3: When no task qualifies, the decision output shows the sentinel NUM_TASKS, busy stays low and no handshake output rises.
- R4: If the running task has not reported completion, preempt_o stays high until task_stopped_i is seen. Then save_req_o stays high until save_ack_i, and after that the outgoing task's status is 11.
- R5: While the block is idle, task_done_i marks the running task stopped (00). A switch decided in that same cycle raises no preempt and no save request.
- R6: If the chosen task is preempted (11), restore_req_o stays high, with active_id_o showing that task, until restore_ack_i. The task then becomes running (10), and no reconfiguration is requested.
- R7: Otherwise cfg_req_o stays high, with active_id_o showing the chosen task, until cfg_done_i. Next comes one cycle of task_rst_o, then one cycle of task_start_o, and then the task is running (10).
- R8: A decision request is accepted only while idle. busy_o is high from the cycle after an accepted switch until the switch completes, and requests made while busy are ignored.
- R9: At most one task is running at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_ready_i | input | 1 | Request to mark a task ready |
| set_id_i | input | IDX_W | Task named by the ready request |
| go_i | input | 1 | Request a scheduling decision |
| task_done_i | input | 1 | The running task has finished its work |
| task_stopped_i | input | 1 | The running task has halted after a preempt |
| save_ack_i | input | 1 | The state save has completed |
| restore_ack_i | input | 1 | The state restore has completed |
| cfg_done_i | input | 1 | The region reconfiguration has completed |
| stat_sel_i | input | IDX_W | Task whose status is shown on stat_o |
| preempt_o | output | 1 | Asks the running task to pause at a safe point |
| save_req_o | output | 1 | Request to save the outgoing task's state |
| restore_req_o | output | 1 | Request to restore the incoming task's state |
| cfg_req_o | output | 1 | Request to reconfigure the region |
| task_rst_o | output | 1 | Reset pulse to the freshly loaded task |
| task_start_o | output | 1 | Start pulse to the freshly loaded task |
| active_id_o | output | IDX_W | Task named by the current handshake |
| choice_o | output | IDX_W | Last decision, or the sentinel NUM_TASKS |
| busy_o | output | 1 | A switch is in progress |
| stat_o | output | 2 | Status of the task selected by stat_sel_i |

## Verification
A wrong status entry appears on stat_o in the cycle after the edge that wrote it. It also changes the next decision, so choice_o and the first handshake output are wrong one cycle after go_i. A switch sequencer stuck in the wrong step shows at once in the handshake outputs: a request held past its acknowledge, a missing reset or start pulse, or busy_o not dropping. A preempted task that is reconfigured instead of restored raises cfg_req_o where restore_req_o was due, in the first cycle of the bring-in.

// File: rtl/hts_pkg.sv
package hts_pkg;
  typedef enum logic [1:0] {
    ST_STOP    = 2'b00,
    ST_READY   = 2'b01,
    ST_RUN     = 2'b10,
    ST_PREEMPT = 2'b11
  } task_st_t;

  typedef enum logic [2:0] {
    SW_IDLE,
    SW_PREEMPT,
    SW_SAVE,
    SW_RESTORE,
    SW_CONFIG,
    SW_RESET,
    SW_LAUNCH
  } sw_state_t;
endpackage

// File: rtl/hts_status_table.sv
module hts_status_table
  import hts_pkg::*;
#(
  parameter int NUM_TASKS = 8,
  parameter int IDX_W     = $clog2(NUM_TASKS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_ready_i,
  input  logic [IDX_W-1:0]     set_id_i,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     wr_id_i,
  input  task_st_t             wr_val_i,
  output task_st_t [NUM_TASKS-1:0] stat_o
);
  task_st_t [NUM_TASKS-1:0] tbl_q, tbl_d;
  logic [NUM_TASKS-1:0] run_vec;

  always_comb begin
    tbl_d = tbl_q;
    for (int i = 0; i < NUM_TASKS; i++) begin
      if (set_ready_i && set_id_i == IDX_W'(i) && tbl_q[i] == ST_STOP)
        tbl_d[i] = ST_READY;
      if (wr_en_i && wr_id_i == IDX_W'(i))
        tbl_d[i] = wr_val_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_TASKS; i++) tbl_q[i] <= ST_STOP;
    end else begin
      tbl_q <= tbl_d;
    end
  end

  generate
    for (genvar g = 0; g < NUM_TASKS; g++) begin : g_run
      assign run_vec[g] = (tbl_q[g] == ST_RUN);
    end
  endgenerate

  assign stat_o = tbl_q;

  assert_single_running_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(run_vec) <= 1)
    else $error("more than one task marked running");
endmodule

// File: rtl/hts_select.sv
module hts_select
  import hts_pkg::*;
#(
  parameter int NUM_TASKS = 8,
  parameter int IDX_W     = $clog2(NUM_TASKS + 1)
) (
  input  task_st_t [NUM_TASKS-1:0] stat_i,
  output logic [IDX_W-1:0]         run_idx_o,
  output logic [IDX_W-1:0]         cand_o
);
  localparam logic [IDX_W-1:0] SENT = IDX_W'(NUM_TASKS);

  always_comb begin
    run_idx_o = SENT;
    for (int i = 0; i < NUM_TASKS; i++)
      if (stat_i[i] == ST_RUN) run_idx_o = IDX_W'(i);
    cand_o = SENT;
    for (int i = NUM_TASKS - 1; i >= 0; i--)
      if (IDX_W'(i) < run_idx_o &&
          (stat_i[i] == ST_READY || stat_i[i] == ST_PREEMPT))
        cand_o = IDX_W'(i);
  end
endmodule

// File: rtl/hts_switch_fsm.sv
module hts_switch_fsm
  import hts_pkg::*;
#(
  parameter int NUM_TASKS = 8,
  parameter int IDX_W     = $clog2(NUM_TASKS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     go_i,
  input  logic                     task_done_i,
  input  logic                     task_stopped_i,
  input  logic                     save_ack_i,
  input  logic                     restore_ack_i,
  input  logic                     cfg_done_i,
  input  task_st_t [NUM_TASKS-1:0] stat_i,
  input  logic [IDX_W-1:0]         run_idx_i,
  input  logic [IDX_W-1:0]         cand_i,
  output logic                     wr_en_o,
  output logic [IDX_W-1:0]         wr_id_o,
  output task_st_t                 wr_val_o,
  output logic                     preempt_o,
  output logic                     save_req_o,
  output logic                     restore_req_o,
  output logic                     cfg_req_o,
  output logic                     task_rst_o,
  output logic                     task_start_o,
  output logic [IDX_W-1:0]         active_id_o,
  output logic [IDX_W-1:0]         choice_o,
  output logic                     busy_o
);
  localparam logic [IDX_W-1:0] SENT = IDX_W'(NUM_TASKS);

  sw_state_t st_q, st_d;
  logic [IDX_W-1:0] new_q, new_d, old_q, old_d;
  logic cand_pre, new_pre;

  always_comb begin
    cand_pre = 1'b0;
    new_pre  = 1'b0;
    for (int i = 0; i < NUM_TASKS; i++) begin
      if (cand_i == IDX_W'(i) && stat_i[i] == ST_PREEMPT) cand_pre = 1'b1;
      if (new_q  == IDX_W'(i) && stat_i[i] == ST_PREEMPT) new_pre  = 1'b1;
    end
  end

  always_comb begin
    st_d     = st_q;
    new_d    = new_q;
    old_d    = old_q;
    wr_en_o  = 1'b0;
    wr_id_o  = old_q;
    wr_val_o = ST_STOP;
    unique case (st_q)
      SW_IDLE: begin
        if (task_done_i && run_idx_i != SENT) begin
          wr_en_o  = 1'b1;
          wr_id_o  = run_idx_i;
          wr_val_o = ST_STOP;
        end
        if (go_i) begin
          new_d = cand_i;
          old_d = run_idx_i;
          if (cand_i != SENT) begin
            if (run_idx_i == SENT || task_done_i)
              st_d = cand_pre ? SW_RESTORE : SW_CONFIG;
            else
              st_d = SW_PREEMPT;
          end
        end
      end
      SW_PREEMPT: if (task_stopped_i) st_d = SW_SAVE;
      SW_SAVE: if (save_ack_i) begin
        wr_en_o  = 1'b1;
        wr_id_o  = old_q;
        wr_val_o = ST_PREEMPT;
        st_d     = new_pre ? SW_RESTORE : SW_CONFIG;
      end
      SW_RESTORE: if (restore_ack_i) begin
        wr_en_o  = 1'b1;
        wr_id_o  = new_q;
        wr_val_o = ST_RUN;
        st_d     = SW_IDLE;
      end
      SW_CONFIG: if (cfg_done_i) st_d = SW_RESET;
      SW_RESET:  st_d = SW_LAUNCH;
      SW_LAUNCH: begin
        wr_en_o  = 1'b1;
        wr_id_o  = new_q;
        wr_val_o = ST_RUN;
        st_d     = SW_IDLE;
      end
      default: st_d = SW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SW_IDLE;
      new_q <= SENT;
      old_q <= SENT;
    end else begin
      st_q  <= st_d;
      new_q <= new_d;
      old_q <= old_d;
    end
  end

  assign preempt_o     = (st_q == SW_PREEMPT);
  assign save_req_o    = (st_q == SW_SAVE);
  assign restore_req_o = (st_q == SW_RESTORE);
  assign cfg_req_o     = (st_q == SW_CONFIG);
  assign task_rst_o    = (st_q == SW_RESET);
  assign task_start_o  = (st_q == SW_LAUNCH);
  assign busy_o        = (st_q != SW_IDLE);
  assign choice_o      = new_q;
  assign active_id_o   = (st_q == SW_PREEMPT || st_q == SW_SAVE) ? old_q : new_q;

  assert_no_switch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && !busy_o && cand_i == SENT) |=> (!busy_o && choice_o == SENT))
    else $error("switch started without a candidate");
  assert_save_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req_o && !save_ack_i) |=> save_req_o)
    else $error("save request dropped before ack");
  assert_preempt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (preempt_o && !task_stopped_i) |=> preempt_o)
    else $error("preempt dropped before task stopped");
  assert_restore_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req_o && restore_ack_i) |=> (!busy_o && stat_i[new_q] == ST_RUN))
    else $error("restored task not running");
  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_o && !cfg_done_i) |=> cfg_req_o)
    else $error("config request dropped before done");
  assert_rst_then_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    task_rst_o |=> (task_start_o && !task_rst_o))
    else $error("start did not follow reset");
  assert_handshake_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({preempt_o, save_req_o, restore_req_o, cfg_req_o, task_rst_o, task_start_o}))
    else $error("several handshake outputs at once");
endmodule

// File: rtl/hw_task_switch.sv
module hw_task_switch
  import hts_pkg::*;
#(
  parameter int NUM_TASKS = 8,
  parameter int IDX_W     = $clog2(NUM_TASKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_ready_i,
  input  logic [IDX_W-1:0] set_id_i,
  input  logic             go_i,
  input  logic             task_done_i,
  input  logic             task_stopped_i,
  input  logic             save_ack_i,
  input  logic             restore_ack_i,
  input  logic             cfg_done_i,
  input  logic [IDX_W-1:0] stat_sel_i,
  output logic             preempt_o,
  output logic             save_req_o,
  output logic             restore_req_o,
  output logic             cfg_req_o,
  output logic             task_rst_o,
  output logic             task_start_o,
  output logic [IDX_W-1:0] active_id_o,
  output logic [IDX_W-1:0] choice_o,
  output logic             busy_o,
  output logic [1:0]       stat_o
);
  task_st_t [NUM_TASKS-1:0] stat;
  logic [IDX_W-1:0] run_idx, cand, wr_id;
  logic wr_en;
  task_st_t wr_val;

  hts_status_table #(.NUM_TASKS(NUM_TASKS), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .set_ready_i(set_ready_i), .set_id_i(set_id_i),
    .wr_en_i(wr_en), .wr_id_i(wr_id), .wr_val_i(wr_val),
    .stat_o(stat)
  );

  hts_select #(.NUM_TASKS(NUM_TASKS), .IDX_W(IDX_W)) u_select (
    .stat_i(stat), .run_idx_o(run_idx), .cand_o(cand)
  );

  hts_switch_fsm #(.NUM_TASKS(NUM_TASKS), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .go_i(go_i),
    .task_done_i(task_done_i), .task_stopped_i(task_stopped_i),
    .save_ack_i(save_ack_i), .restore_ack_i(restore_ack_i), .cfg_done_i(cfg_done_i),
    .stat_i(stat), .run_idx_i(run_idx), .cand_i(cand),
    .wr_en_o(wr_en), .wr_id_o(wr_id), .wr_val_o(wr_val),
    .preempt_o(preempt_o), .save_req_o(save_req_o), .restore_req_o(restore_req_o),
    .cfg_req_o(cfg_req_o), .task_rst_o(task_rst_o), .task_start_o(task_start_o),
    .active_id_o(active_id_o), .choice_o(choice_o), .busy_o(busy_o)
  );

  always_comb begin
    stat_o = 2'b00;
    for (int i = 0; i < NUM_TASKS; i++)
      if (stat_sel_i == IDX_W'(i)) stat_o = stat[i];
  end
endmodule

// File: tb/sim_hw_task_switch.sv
module sim_hw_task_switch;
  localparam int N = 8;
  localparam int W = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic set_ready = 0, go = 0, done = 0, stopped = 0;
  logic save_ack = 0, restore_ack = 0, cfg_done = 0;
  logic [W-1:0] set_id = '0, stat_sel = '0;
  logic preempt, save_req, restore_req, cfg_req, trst, tstart, busy;
  logic [W-1:0] active_id, choice;
  logic [1:0] stat;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  hw_task_switch #(.NUM_TASKS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .set_ready_i(set_ready), .set_id_i(set_id),
    .go_i(go), .task_done_i(done), .task_stopped_i(stopped),
    .save_ack_i(save_ack), .restore_ack_i(restore_ack), .cfg_done_i(cfg_done),
    .stat_sel_i(stat_sel), .preempt_o(preempt), .save_req_o(save_req),
    .restore_req_o(restore_req), .cfg_req_o(cfg_req), .task_rst_o(trst),
    .task_start_o(tstart), .active_id_o(active_id), .choice_o(choice),
    .busy_o(busy), .stat_o(stat)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_stat(input string tag, input int id, input int exp);
    stat_sel = W'(id);
    #1;
    chk(tag, int'(stat), exp);
  endtask

  task automatic mark_ready(input int id);
    set_ready = 1; set_id = W'(id);
    step();
    set_ready = 0;
  endtask

  // fresh bring-in: expects CONFIG state now, finishes with task running
  task automatic finish_fresh(input string tag, input int id);
    chk({tag, " cfg_req"}, int'(cfg_req), 1);
    chk({tag, " active"}, int'(active_id), id);
    repeat (2) step();
    chk({tag, " cfg_req held"}, int'(cfg_req), 1);
    cfg_done = 1;
    step();
    cfg_done = 0;
    chk({tag, " rst pulse"}, int'(trst), 1);
    chk({tag, " cfg dropped"}, int'(cfg_req), 0);
    step();
    chk({tag, " start pulse"}, int'(tstart), 1);
    chk({tag, " rst one cycle"}, int'(trst), 0);
    step();
    chk({tag, " idle"}, int'(busy), 0);
    chk_stat({tag, " running"}, id, 2);
  endtask

  task automatic t_reset();
    chk("R8 reset busy", int'(busy), 0);
    chk("R3 reset choice sentinel", int'(choice), N);
    for (int i = 0; i < N; i++) chk_stat("R1 reset stopped", i, 0);
  endtask

  task automatic t_empty();
    go = 1; step(); go = 0;
    chk("R3 no cand busy", int'(busy), 0);
    chk("R3 no cand choice", int'(choice), N);
    chk("R3 no cand cfg", int'(cfg_req), 0);
  endtask

  task automatic t_first();
    mark_ready(5);
    chk_stat("R1 stopped to ready", 5, 1);
    go = 1; step(); go = 0;
    chk("R2 first choice", int'(choice), 5);
    chk("R8 busy", int'(busy), 1);
    chk("R7 no restore", int'(restore_req), 0);
    finish_fresh("R7 task5", 5);
  endtask

  task automatic t_lower();
    mark_ready(6);
    go = 1; step(); go = 0;
    chk("R3 lower prio ignored busy", int'(busy), 0);
    chk("R3 lower prio choice", int'(choice), N);
    chk_stat("R2 task6 still ready", 6, 1);
    chk_stat("R2 task5 still running", 5, 2);
    mark_ready(5);
    chk_stat("R1 ready on running ignored", 5, 2);
  endtask

  task automatic t_preempt();
    mark_ready(2);
    go = 1; step(); go = 0;
    chk("R2 choice 2", int'(choice), 2);
    chk("R4 preempt", int'(preempt), 1);
    chk("R4 active old", int'(active_id), 5);
    repeat (3) step();
    chk("R4 preempt held", int'(preempt), 1);
    chk("R4 no save yet", int'(save_req), 0);
    stopped = 1; step(); stopped = 0;
    chk("R4 save_req", int'(save_req), 1);
    chk("R4 preempt dropped", int'(preempt), 0);
    chk("R4 save active old", int'(active_id), 5);
    step();
    chk("R4 save held", int'(save_req), 1);
    save_ack = 1; step(); save_ack = 0;
    chk_stat("R4 old preempted", 5, 3);
    finish_fresh("R7 task2", 2);
  endtask

  task automatic t_retire_restore();
    done = 1; step(); done = 0;
    chk_stat("R5 done marks stopped", 2, 0);
    chk("R5 idle after done", int'(busy), 0);
    go = 1; step(); go = 0;
    chk("R2 preempted beats ready", int'(choice), 5);
    chk("R6 restore_req", int'(restore_req), 1);
    chk("R6 no cfg", int'(cfg_req), 0);
    chk("R6 active", int'(active_id), 5);
    step();
    chk("R6 restore held", int'(restore_req), 1);
    restore_ack = 1; step(); restore_ack = 0;
    chk("R6 idle", int'(busy), 0);
    chk_stat("R6 running", 5, 2);
  endtask

  task automatic t_done_switch();
    mark_ready(1);
    done = 1; go = 1; step(); done = 0; go = 0;
    chk("R5 no preempt", int'(preempt), 0);
    chk("R5 no save", int'(save_req), 0);
    chk_stat("R5 retired", 5, 0);
    chk("R2 choice 1", int'(choice), 1);
    // go while busy is ignored
    go = 1; step(); go = 0;
    chk("R8 busy go ignored choice", int'(choice), 1);
    finish_fresh("R7 task1", 1);
    chk("R8 no restart", int'(busy), 0);
    chk_stat("R9 task6 not running", 6, 1);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_empty();
    t_first();
    t_lower();
    t_preempt();
    t_retire_restore();
    t_done_switch();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule